// File: doc/BRIEF.md
# PN chip spreader and despreader

This block is a direct-sequence spreading pair. A transmit half takes one data bit at a time through a valid/ready handshake. It sends that bit as one full period of pseudo-noise chips, each chip being the data bit XORed with the next output of a maximal-length linear feedback shift register. A receive half runs its own identical generator. For every chip it is handed, it XORs the chip with the local sequence, counts the despread ones, and at the end of the period decides the bit by majority.

Three preset feedback polynomials are available, with 3, 5 and 8 stages. A two-bit selection input chooses among them, and it is captured only while reset is held. Each data bit is aligned to the start of the sequence: both generators restart from the seed at every bit boundary, so the transmitter and receiver stay in step as long as the receiver sees every valid chip. In the usual setup the chip output is looped back to the chip input, either directly or through a channel model that can corrupt chips.

Top module: `pn_dsss_top`

## Requirements
- R1: The poly_sel code captured during reset picks the sequence. Code 0 selects 3 stages with period 7. Code 1 selects 5 stages with period 31. Codes 2 and 3 select 8 stages with period 255.
- R2: With stages numbered from 0, the new value always enters the top stage and every other stage takes the value of the stage above it. Each chip is taken from stage 0. The feedback is the XOR of stages {2,0} for 3 stages, {4,3,1,0} for 5 stages and {7,6,5,2,1,0} for 8 stages. Stages above the selected length stay 0.
- R3: The generator never holds the all-zero state. Over one period, the chips of a 0 data bit contain (P+1)/2 ones.
- R4: The SEED parameter is masked to the selected length and loaded at reset. A seed that is zero after masking is replaced by all ones, so a SEED of zero gives the same chip stream as the default seed of all ones.
- R5: din_ready is high when the transmitter is idle or is presenting the last chip of a bit. A bit accepted on a clock edge has its first chip on chip_out with chip_valid high after the second following edge. Bits offered back to back produce a chip stream with no gaps.
- R6: Bit b yields exactly P chips, where chip k is b XOR s_k and s_k is the generator output k steps after the seed.
- R7: The receiver counts the ones in chip_in XOR its local sequence over P valid chips. It restarts its phase and its count after each group of P chips. It recovers a 1 exactly when that count exceeds (P-1)/2, so up to (P-1)/2 corrupted chips per bit are corrected.
- R8: rx_valid pulses for exactly one cycle, in the cycle after the clock edge that takes the last chip of a group. rx_bit holds its value between pulses.
- R9: A change of poly_sel while reset is low has no effect until the next reset.
- R10: While reset is held, din_ready is 1, and chip_valid, chip_out, rx_valid and rx_bit are all 0.
- R11: chip_in is ignored in cycles where chip_in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| poly_sel | input | 2 | Polynomial selection, captured during reset |
| din | input | 1 | Data bit to spread |
| din_valid | input | 1 | din holds a bit to send |
| din_ready | output | 1 | Transmitter can take a bit this cycle |
| chip_out | output | 1 | Spread chip stream |
| chip_valid | output | 1 | chip_out carries a chip |
| chip_in | input | 1 | Received chip |
| chip_in_valid | input | 1 | chip_in carries a chip |
| rx_bit | output | 1 | Recovered data bit |
| rx_valid | output | 1 | One-cycle pulse when rx_bit is new |

## Verification
The assertions check several properties on every cycle. The generator state must never be zero and no bit may be set above the selected length. The transmitter must show a chip two edges after an accept, and it must keep chipping while it refuses new data. The receiver's ones count must never exceed its chip count, rx_valid must be a single-cycle pulse, and the captured polynomial selection must stay fixed outside reset.

Some behaviour shows only in the bench's scenarios: the actual chip values for each polynomial, the majority threshold exactly at (P-1)/2 and (P+1)/2 corrupted chips, the ones balance of a period, the zero-seed substitution, ignoring chip_in during idle gaps, and a selection change without a reset. For these the bench compares the outputs against a behavioural recurrence model on every clock.

// File: rtl/pn_dsss_pkg.sv
package pn_dsss_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int STATE_W = 8;

  typedef enum logic [1:0] {
    PN_DEG3   = 2'd0,
    PN_DEG5   = 2'd1,
    PN_DEG8   = 2'd2,
    PN_DEG8_B = 2'd3
  } pn_sel_e;

  // Stages XORed to form the feedback bit
  function automatic logic [STATE_W-1:0] fb_taps(pn_sel_e s);
    case (s)
      PN_DEG3: return STATE_W'(8'b0000_0101);
      PN_DEG5: return STATE_W'(8'b0001_1011);
      default: return STATE_W'(8'b1110_0111);
    endcase
  endfunction

  // Stages in use; numerically equal to the period
  function automatic logic [STATE_W-1:0] used_mask(pn_sel_e s);
    case (s)
      PN_DEG3: return STATE_W'(8'h07);
      PN_DEG5: return STATE_W'(8'h1F);
      default: return STATE_W'(8'hFF);
    endcase
  endfunction

  // One-hot position of the stage that receives the feedback
  function automatic logic [STATE_W-1:0] entry_stage(pn_sel_e s);
    case (s)
      PN_DEG3: return STATE_W'(8'h04);
      PN_DEG5: return STATE_W'(8'h10);
      default: return STATE_W'(8'h80);
    endcase
  endfunction
endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] taps,
  input  logic [W-1:0] entry_oh,
  input  logic [W-1:0] len_mask,
  input  logic         restart,
  input  logic         step,
  output logic         chip
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] state_q;
  logic [W-1:0] nxt_w;
  logic         fb_w;

  assign fb_w = ^(state_q & taps);

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == W - 1) begin : g_last
      assign nxt_w[i] = entry_oh[i] & fb_w;
    end else begin : g_inner
      assign nxt_w[i] = entry_oh[i] ? fb_w : state_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) state_q <= seed;
    else if (step)      state_q <= nxt_w;
  end

  assign chip = state_q[0];

  // R3
  state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0)
    else $error("generator reached the all-zero state");

  // R2
  upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q & ~len_mask) == '0)
    else $error("stage above selected length is set");
endmodule

// File: rtl/pn_spreader.sv
module pn_spreader #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] taps,
  input  logic [W-1:0] entry_oh,
  input  logic [W-1:0] len_mask,
  input  logic [W-1:0] last_idx,
  input  logic         din,
  input  logic         din_valid,
  output logic         din_ready,
  output logic         chip_out,
  output logic         chip_valid
);
  timeunit 1ns;
  timeprecision 1ps;

  logic         busy_q;
  logic         bit_q;
  logic [W-1:0] idx_q;
  logic         last_w;
  logic         accept_w;
  logic         pn_w;

  assign last_w    = busy_q && (idx_q == last_idx);
  assign din_ready = !busy_q || last_w;
  assign accept_w  = din_valid && din_ready;

  pn_lfsr #(.W(W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .seed     (seed),
    .taps     (taps),
    .entry_oh (entry_oh),
    .len_mask (len_mask),
    .restart  (accept_w || last_w),
    .step     (busy_q),
    .chip     (pn_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      bit_q      <= 1'b0;
      idx_q      <= '0;
      chip_out   <= 1'b0;
      chip_valid <= 1'b0;
    end else begin
      chip_valid <= busy_q;
      chip_out   <= busy_q & (bit_q ^ pn_w);
      if (accept_w) begin
        bit_q  <= din;
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (last_w) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R5
  accept_to_chip_chk: assert property (@(posedge clk) disable iff (rst)
    (din_valid && din_ready) |-> ##2 chip_valid)
    else $error("no chip two edges after accept");

  // R5
  stall_chipping_chk: assert property (@(posedge clk) disable iff (rst)
    !din_ready |=> chip_valid)
    else $error("transmitter refused data while not chipping");
endmodule

// File: rtl/pn_despreader.sv
module pn_despreader #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] taps,
  input  logic [W-1:0] entry_oh,
  input  logic [W-1:0] len_mask,
  input  logic [W-1:0] last_idx,
  input  logic         chip_in,
  input  logic         chip_in_valid,
  output logic         rx_bit,
  output logic         rx_valid
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] cnt_q;
  logic [W-1:0] ones_q;
  logic [W-1:0] total_w;
  logic         pn_w;
  logic         desp_w;
  logic         last_w;

  assign desp_w  = chip_in ^ pn_w;
  assign last_w  = chip_in_valid && (cnt_q == last_idx);
  assign total_w = ones_q + W'(desp_w);

  pn_lfsr #(.W(W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .seed     (seed),
    .taps     (taps),
    .entry_oh (entry_oh),
    .len_mask (len_mask),
    .restart  (last_w),
    .step     (chip_in_valid),
    .chip     (pn_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      ones_q   <= '0;
      rx_bit   <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (last_w) begin
        rx_bit   <= (total_w > (last_idx >> 1));
        rx_valid <= 1'b1;
        cnt_q    <= '0;
        ones_q   <= '0;
      end else if (chip_in_valid) begin
        cnt_q  <= cnt_q + 1'b1;
        ones_q <= total_w;
      end
    end
  end

  // R7
  ones_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    ones_q <= cnt_q)
    else $error("ones count exceeds chip count");

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid)
    else $error("rx_valid longer than one cycle");
endmodule

// File: rtl/pn_dsss_top.sv
module pn_dsss_top
  import pn_dsss_pkg::*;
#(
  parameter logic [STATE_W-1:0] SEED = '1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] poly_sel,
  input  logic       din,
  input  logic       din_valid,
  output logic       din_ready,
  output logic       chip_out,
  output logic       chip_valid,
  input  logic       chip_in,
  input  logic       chip_in_valid,
  output logic       rx_bit,
  output logic       rx_valid
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0]         sel_q;
  pn_sel_e            cfg_sel;
  logic [STATE_W-1:0] taps_w;
  logic [STATE_W-1:0] mask_w;
  logic [STATE_W-1:0] entry_w;
  logic [STATE_W-1:0] seed_m;
  logic [STATE_W-1:0] seed_w;
  logic [STATE_W-1:0] last_w;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= poly_sel;
  end

  // during reset the live selection seeds the generators
  assign cfg_sel = pn_sel_e'(rst ? poly_sel : sel_q);
  assign taps_w  = fb_taps(cfg_sel);
  assign mask_w  = used_mask(cfg_sel);
  assign entry_w = entry_stage(cfg_sel);
  assign seed_m  = SEED & mask_w;
  assign seed_w  = (seed_m == '0) ? mask_w : seed_m;
  assign last_w  = mask_w - 1'b1;

  pn_spreader #(.W(STATE_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .seed       (seed_w),
    .taps       (taps_w),
    .entry_oh   (entry_w),
    .len_mask   (mask_w),
    .last_idx   (last_w),
    .din        (din),
    .din_valid  (din_valid),
    .din_ready  (din_ready),
    .chip_out   (chip_out),
    .chip_valid (chip_valid)
  );

  pn_despreader #(.W(STATE_W)) u_rx (
    .clk           (clk),
    .rst           (rst),
    .seed          (seed_w),
    .taps          (taps_w),
    .entry_oh      (entry_w),
    .len_mask      (mask_w),
    .last_idx      (last_w),
    .chip_in       (chip_in),
    .chip_in_valid (chip_in_valid),
    .rx_bit        (rx_bit),
    .rx_valid      (rx_valid)
  );

  // R9
  sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(sel_q))
    else $error("polynomial selection moved outside reset");
endmodule

// File: tb/pn_dsss_top_tb.sv
module pn_dsss_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] poly_sel = 2'd0;
  logic din = 1'b0;
  logic din_valid = 1'b0;
  logic flip = 1'b0;
  logic din_ready, chip_out, chip_valid, rx_bit, rx_valid, chip_in;
  logic z_ready, z_chip, z_cvalid, z_rxbit, z_rxvalid;

  always #2 clk = ~clk;

  assign chip_in = chip_out ^ flip;

  pn_dsss_top dut_i (
    .clk(clk), .rst(rst), .poly_sel(poly_sel), .din(din), .din_valid(din_valid),
    .din_ready(din_ready), .chip_out(chip_out), .chip_valid(chip_valid),
    .chip_in(chip_in), .chip_in_valid(chip_valid), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  // R4 twin with an all-zero seed
  pn_dsss_top #(.SEED('0)) dut_z (
    .clk(clk), .rst(rst), .poly_sel(poly_sel), .din(din), .din_valid(din_valid),
    .din_ready(z_ready), .chip_out(z_chip), .chip_valid(z_cvalid),
    .chip_in(z_chip), .chip_in_valid(z_cvalid), .rx_bit(z_rxbit), .rx_valid(z_rxvalid)
  );

  int checks = 0;
  int errors = 0;
  bit pn_seq [0:254];
  int per = 7;
  bit txq[$];
  bit srcq[$];
  bit sentq[$];
  bit pend = 0;
  bit pend_bit = 0;
  int rxc = 0, fcnt = 0, ones = 0, nflip = 0;
  bit rx_due = 0, rx_exp = 0, gappy = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // sequence from recurrence a[n+L] = XOR of a[n+t]; start all ones
  task automatic build(int s);
    int L;
    int tp[$];
    bit a [0:262];
    bit x;
    case (s)
      0: begin L = 3; tp = '{2, 0}; end
      1: begin L = 5; tp = '{4, 3, 1, 0}; end
      default: begin L = 8; tp = '{7, 6, 5, 2, 1, 0}; end
    endcase
    per = (1 << L) - 1;
    for (int n = 0; n < L; n++) a[n] = 1'b1;
    for (int n = 0; n + L < 263; n++) begin
      x = 1'b0;
      foreach (tp[k]) x ^= a[n + tp[k]];
      a[n + L] = x;
    end
    for (int n = 0; n < 255; n++) pn_seq[n] = a[n];
  endtask

  task automatic do_reset(int s);
    @(negedge clk);
    rst = 1'b1; poly_sel = 2'(s); din_valid = 1'b0; flip = 1'b0;
    build(s);
    txq.delete(); srcq.delete(); sentq.delete();
    pend = 0; rxc = 0; fcnt = 0; ones = 0; rx_due = 0;
    repeat (3) @(negedge clk);
    chk(din_ready == 1'b1, "R10", "din_ready in reset", din_ready, 1);
    chk(chip_valid == 1'b0, "R10", "chip_valid in reset", chip_valid, 0);
    chk(chip_out == 1'b0, "R10", "chip_out in reset", chip_out, 0);
    chk(rx_valid == 1'b0, "R10", "rx_valid in reset", rx_valid, 0);
    chk(rx_bit == 1'b0, "R10", "rx_bit in reset", rx_bit, 0);
    rst = 1'b0;
  endtask

  task automatic tick();
    bit e;
    bit b;
    @(negedge clk);
    // transmit side
    chk(chip_valid == (txq.size() > 0), "R5", "chip_valid", chip_valid, txq.size() > 0);
    if (txq.size() > 0) begin
      e = txq.pop_front();
      chk(chip_out == e, "R1 R2 R6", "chip value", chip_out, e);
    end
    chk(z_chip == chip_out && z_cvalid == chip_valid, "R4", "zero-seed twin chip",
        {z_cvalid, z_chip}, {chip_valid, chip_out});
    // receive side
    chk(rx_valid == rx_due, "R8", "rx_valid", rx_valid, rx_due);
    if (rx_due) chk(rx_bit == rx_exp, "R7", "recovered bit", rx_bit, rx_exp);
    rx_due = 0;
    // channel for the chip taken at the coming edge
    if (chip_valid) begin
      flip = (rxc < nflip);
      if (flip) fcnt++;
      if (chip_out) ones++;
      rxc++;
      if (rxc == per) begin
        b = sentq.pop_front();
        rx_exp = b ^ (2 * fcnt > per);
        rx_due = 1;
        if (!b) chk(ones == (per + 1) / 2, "R3", "ones in one period", ones, (per + 1) / 2);
        rxc = 0; fcnt = 0; ones = 0;
      end
    end else begin
      flip = 1'($urandom_range(1, 0)); // R11 garbage while chip_in_valid is low
    end
    if (pend) begin
      for (int k = 0; k < per; k++) txq.push_back(pend_bit ^ pn_seq[k]);
      pend = 0;
    end
    chk(din_ready == (txq.size() <= 1), "R5", "din_ready", din_ready, txq.size() <= 1);
    // stimulus
    din_valid = (srcq.size() > 0) && (!gappy || ($urandom_range(3, 0) == 0));
    din = (srcq.size() > 0) ? srcq[0] : 1'b0;
    if (din_valid && din_ready) begin
      void'(srcq.pop_front());
      pend = 1; pend_bit = din;
      sentq.push_back(din);
    end
  endtask

  task automatic send(bit bits[$], int nf, bit gaps);
    nflip = nf; gappy = gaps;
    foreach (bits[i]) srcq.push_back(bits[i]);
    while (srcq.size() > 0 || pend || txq.size() > 0 || sentq.size() > 0 || rx_due) tick();
    repeat (3) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R5", "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R1 R2 R6: 3-stage, back to back
    do_reset(0);
    send('{1, 0, 1, 1, 0, 0}, 0, 0);
    // R7 R11: gaps, majority at (P-1)/2 corrupted chips, then one more
    send('{1, 0, 1, 0}, 3, 1);
    send('{1, 0, 0, 1}, 4, 1);
    // R1: 5-stage
    do_reset(1);
    send('{0, 1, 1, 0}, 15, 0);
    send('{1, 0}, 16, 1);
    // R9: selection change without reset keeps the 5-stage sequence
    poly_sel = 2'd2;
    send('{1, 0, 1}, 0, 0);
    // R1 R3: 8-stage
    do_reset(2);
    send('{0, 1, 0}, 127, 0);
    send('{1}, 128, 0);
    // R1: code 3 also 8-stage
    do_reset(3);
    send('{1, 0}, 0, 1);
    summary();
    $finish;
  end
endmodule